// File: doc/BRIEF.md
# MSI Interrupt Message Generator

This block converts the outbound interrupt events of an endpoint into message-signalled interrupt (MSI) memory-write requests. It holds a 16-bit message data register. Both the host configuration path and the local processor path can write it, and its value is visible on an output for read-back. Two source groups raise events: a post-queue interrupt, and a combined doorbell/message interrupt. Each group has a pending flag. A rising edge on its event input sets the flag, and an accepted write clears it.

The message-count setting from configuration space selects how the data word is built. With two messages allocated (code 3'b001), the lowest data bit is forced per group, so each group reaches its own interrupt vector. With any other code, one message is shared, the register value goes out unchanged, and one write serves every pending source. The write is presented to a bus master on a request/grant pair. The 32-bit data word carries the message in its low half and zeros in its high half, and all byte enables are active.

The control is a two-state machine. **S_IDLE** keeps the request low. The transition *launch* (S_IDLE to S_REQ) fires when MSI is enabled and at least one flag is pending; it captures the address, the data word, the chosen group and the mode. **S_REQ** holds the request high with frozen outputs. The transition *accept* (S_REQ to S_IDLE) fires on the grant and clears the served flags. While S_REQ is waiting for a grant it takes the transition *hold* back to itself.

Top module: `msi_msg_gen`

## Requirements
- R1: The message data register resets to 0x0000. A host or local write appears on `msg_data` one cycle later. When both write in the same cycle, the host value is kept.
- R2: While `req` is high, `req_data[31:16]` is zero and `req_be` is 4'b1111.
- R3: With `mme` = 3'b001, `req_data[15:1]` equals register bits [15:1]. Bit 0 is 0 for a post-queue write and 1 for a doorbell/message write.
- R4: With any `mme` other than 3'b001, `req_data[15:0]` equals the register unchanged, including bit 0. A single accepted write clears both pending flags.
- R5: A rising edge on an event input sets that group's pending flag. Further edges before the write is accepted merge into it, so only one write results.
- R6: With `mme` = 3'b001 and both groups pending, the post-queue write (bit 0 = 0) is issued first and the doorbell/message write (bit 0 = 1) follows.
- R7: While `msi_en` is low, `req` stays low and pending flags are kept. Once `msi_en` is high, `req` rises at the next clock edge.
- R8: `req` stays high with stable `req_addr`, `req_data` and `req_be` until the cycle in which `gnt` is high. It is low in the following cycle, so requests are separated by at least one low cycle.
- R9: An event edge sampled at clock edge k, with `msi_en` high and the machine idle, makes `req` high after edge k+1. `req_addr` equals `msi_addr` as sampled at that launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host configuration write strobe for the message data |
| host_wdata | input | 16 | Host write value |
| loc_we | input | 1 | Local-side write strobe for the message data |
| loc_wdata | input | 16 | Local write value |
| msg_data | output | 16 | Current message data register contents |
| mme | input | 3 | Allocated message count code (3'b001 = two messages) |
| msi_en | input | 1 | Global MSI enable |
| msi_addr | input | 32 | Target address of the MSI write |
| ev_postq | input | 1 | Post-queue interrupt event |
| ev_dbmsg | input | 1 | Doorbell/message interrupt event |
| req | output | 1 | Write request to the bus master |
| req_addr | output | 32 | Address of the requested write |
| req_data | output | 32 | Data word of the requested write |
| req_be | output | 4 | Byte enables of the requested write |
| gnt | input | 1 | Grant; a write is accepted when `req` and `gnt` are both high |

## Verification
A register write becomes visible on `msg_data` one cycle after its strobe. The bench drives every input just after a falling edge and samples one edge later, at the next falling edge. An event needs two rising edges to reach `req`: one to set the pending flag and one to launch. The bench therefore checks that `req` is still low after the first edge and high after the second. After a grant, `req` is low at the very next falling edge. In two-message mode the follow-up request is due one cycle after that. Each check for "no further write" watches four idle cycles.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int MSG_W     = 16;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 32;
    localparam int NSRC      = 2;
    localparam int SRC_POSTQ = 0;
    localparam int SRC_DBMSG = 1;
    localparam logic [2:0] MME_TWO = 3'b001;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_REQ  = 1'b1
    } req_state_e;
endpackage

// File: rtl/msi_data_reg.sv
module msi_data_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_we,
    input  logic [W-1:0] host_wdata,
    input  logic         loc_we,
    input  logic [W-1:0] loc_wdata,
    output logic [W-1:0] value
);
    logic [W-1:0] val_q;

    // host path has priority on a same-cycle collision
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (host_we) val_q <= host_wdata;
        else if (loc_we)  val_q <= loc_wdata;
    end

    assign value = val_q;
endmodule

// File: rtl/msi_pend.sv
module msi_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic clr,
    output logic pend
);
    logic ev_q;
    logic pend_q;
    logic rise;

    assign rise = ev & ~ev_q;

    // a new edge wins over a clear in the same cycle so no event is lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            ev_q   <= ev;
            pend_q <= rise | (pend_q & ~clr);
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int MW = 16,
    parameter int BW = 32,
    parameter int AW = 32,
    parameter int NS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   pend,
    input  logic            msi_en,
    input  logic            two_mode,
    input  logic            gnt,
    input  logic [MW-1:0]   msg_val,
    input  logic [AW-1:0]   addr_in,
    output logic            req,
    output logic [AW-1:0]   req_addr,
    output logic [BW-1:0]   req_data,
    output logic [BW/8-1:0] req_be,
    output logic [NS-1:0]   clr
);
    localparam int PAD_W = BW - MW;

    req_state_e state_q, state_d;
    logic          launch;
    logic          accept;
    logic          pick_db;
    logic          grp_db_q;
    logic          two_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] data_q;
    logic [BW-1:0] data_d;

    assign launch = msi_en && (|pend);
    assign accept = (state_q == S_REQ) && gnt;

    // post-queue first when two vectors are in use
    assign pick_db = two_mode && !pend[SRC_POSTQ];

    always_comb begin
        data_d = {{PAD_W{1'b0}}, msg_val};
        if (two_mode) data_d[0] = pick_db;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_d = S_REQ;   // launch
            S_REQ:  if (gnt)    state_d = S_IDLE;  // accept, else hold
            default:            state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_db_q <= 1'b0;
            two_q    <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else if (state_q == S_IDLE && launch) begin
            grp_db_q <= pick_db;
            two_q    <= two_mode;
            addr_q   <= addr_in;
            data_q   <= data_d;
        end
    end

    always_comb begin
        req       = (state_q == S_REQ);
        req_addr  = addr_q;
        req_data  = data_q;
        req_be    = '1;
        clr       = '0;
        clr[SRC_POSTQ] = accept && (!two_q || !grp_db_q);
        clr[SRC_DBMSG] = accept && (!two_q ||  grp_db_q);
    end
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [MSG_W-1:0]  host_wdata,
    input  logic              loc_we,
    input  logic [MSG_W-1:0]  loc_wdata,
    output logic [MSG_W-1:0]  msg_data,
    input  logic [2:0]        mme,
    input  logic              msi_en,
    input  logic [ADDR_W-1:0] msi_addr,
    input  logic              ev_postq,
    input  logic              ev_dbmsg,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BUS_W-1:0]  req_data,
    output logic [BUS_W/8-1:0] req_be,
    input  logic              gnt
);
    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] pend_vec;
    logic [NSRC-1:0] clr_vec;
    logic            two_mode;

    assign ev_vec[SRC_POSTQ] = ev_postq;
    assign ev_vec[SRC_DBMSG] = ev_dbmsg;
    assign two_mode = (mme == MME_TWO);

    msi_data_reg #(.W(MSG_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .loc_we     (loc_we),
        .loc_wdata  (loc_wdata),
        .value      (msg_data)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        msi_pend u_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev_vec[g]),
            .clr   (clr_vec[g]),
            .pend  (pend_vec[g])
        );
    end

    msi_req_fsm #(.MW(MSG_W), .BW(BUS_W), .AW(ADDR_W), .NS(NSRC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_vec),
        .msi_en   (msi_en),
        .two_mode (two_mode),
        .gnt      (gnt),
        .msg_val  (msg_data),
        .addr_in  (msi_addr),
        .req      (req),
        .req_addr (req_addr),
        .req_data (req_data),
        .req_be   (req_be),
        .clr      (clr_vec)
    );
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [15:0] host_wdata,
    input logic [15:0] msg_data,
    input logic        msi_en,
    input logic        req,
    input logic [31:0] req_addr,
    input logic [31:0] req_data,
    input logic [3:0]  req_be,
    input logic        gnt
);
    // R1
    host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_we) |-> msg_data == $past(host_wdata));

    // R2
    word_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (req_data[31:16] == 16'h0) && (req_be == 4'hF));

    // R7
    no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_en && !req) |=> !req);

    // R8
    hold_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> req && $stable(req_addr) && $stable(req_data) && $stable(req_be));

    // R8
    gap_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt) |=> !req);
endmodule

bind msi_msg_gen msi_msg_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .msg_data   (msg_data),
    .msi_en     (msi_en),
    .req        (req),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_be     (req_be),
    .gnt        (gnt)
);

// File: tb/msi_msg_gen_bench.sv
module msi_msg_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        loc_we = 1'b0;
    logic [15:0] loc_wdata = '0;
    logic [15:0] msg_data;
    logic [2:0]  mme = 3'b000;
    logic        msi_en = 1'b1;
    logic [31:0] msi_addr = 32'hFEE0_1000;
    logic        ev_postq = 1'b0;
    logic        ev_dbmsg = 1'b0;
    logic        req;
    logic [31:0] req_addr;
    logic [31:0] req_data;
    logic [3:0]  req_be;
    logic        gnt = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msi_msg_gen u_msi_msg_gen (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic [15:0] v);
        @(negedge clk); host_we = 1'b1; host_wdata = v;
        @(negedge clk); host_we = 1'b0;
    endtask

    // pulse at a negedge; after return (next negedge) the flag is set, req not yet high
    task automatic pulse(logic p, logic d);
        @(negedge clk); ev_postq = p; ev_dbmsg = d;
        @(negedge clk); ev_postq = 1'b0; ev_dbmsg = 1'b0;
    endtask

    task automatic grant;
        gnt = 1'b1;
        @(negedge clk); gnt = 1'b0;
    endtask

    task automatic quiet(string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tag, req, 1'b0);
        end
    endtask

    task automatic t_reset;
        check("R1 reset msg_data", msg_data, 16'h0);
        check("R8 reset req", req, 1'b0);
    endtask

    task automatic t_regs;
        host_wr(16'h1234);
        check("R1 host write", msg_data, 16'h1234);
        @(negedge clk); loc_we = 1'b1; loc_wdata = 16'hBEEF;
        @(negedge clk); loc_we = 1'b0;
        check("R1 local write", msg_data, 16'hBEEF);
        @(negedge clk); host_we = 1'b1; host_wdata = 16'h0A0A; loc_we = 1'b1; loc_wdata = 16'h5555;
        @(negedge clk); host_we = 1'b0; loc_we = 1'b0;
        check("R1 host wins", msg_data, 16'h0A0A);
    endtask

    task automatic t_one_msg;
        mme = 3'b000;
        host_wr(16'h0A0B);
        pulse(1'b0, 1'b1);
        check("R9 req not yet", req, 1'b0);
        @(negedge clk);
        check("R9 req due", req, 1'b1);
        check("R4 one-msg data", req_data, 32'h0000_0A0B);
        check("R2 byte enables", req_be, 4'hF);
        check("R9 address", req_addr, 32'hFEE0_1000);
        msi_addr = 32'h1111_2222;
        repeat (3) @(negedge clk);
        check("R8 held req", req, 1'b1);
        check("R8 held data", req_data, 32'h0000_0A0B);
        check("R8 held addr", req_addr, 32'hFEE0_1000);
        msi_addr = 32'hFEE0_1000;
        grant();
        check("R8 drop after grant", req, 1'b0);
        quiet("R5 single write");
    endtask

    task automatic t_two_msg;
        mme = 3'b001;
        pulse(1'b1, 1'b1);
        @(negedge clk);
        check("R6 first req", req, 1'b1);
        check("R3 postq bit0=0", req_data, 32'h0000_0A0A);
        grant();
        check("R8 gap", req, 1'b0);
        @(negedge clk);
        check("R6 second req", req, 1'b1);
        check("R3 dbmsg bit0=1", req_data, 32'h0000_0A0B);
        grant();
        quiet("R6 only two writes");
    endtask

    task automatic t_one_both;
        mme = 3'b000;
        pulse(1'b1, 1'b1);
        @(negedge clk);
        check("R4 shared req", req_data, 32'h0000_0A0B);
        grant();
        quiet("R4 both cleared");
    endtask

    task automatic t_other_mme;
        mme = 3'b011;
        host_wr(16'h0A0A);
        pulse(1'b0, 1'b1);
        @(negedge clk);
        check("R4 mme=011 unmodified", req_data, 32'h0000_0A0A);
        grant();
        quiet("R4 mme=011 one write");
    endtask

    task automatic t_merge;
        mme = 3'b001;
        pulse(1'b1, 1'b0);
        @(negedge clk);
        check("R5 req up", req, 1'b1);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        grant();
        quiet("R5 merged");
    endtask

    task automatic t_enable;
        mme = 3'b000;
        msi_en = 1'b0;
        pulse(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check("R7 blocked", req, 1'b0);
        msi_en = 1'b1;
        @(negedge clk);
        check("R7 released", req, 1'b1);
        grant();
        quiet("R7 one write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_one_msg();
        t_two_msg();
        t_one_both();
        t_other_mme();
        t_merge();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule